// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block sits behind a clock-and-data recovery stage. It takes a recovered serial stream one bit at a time and groups the bits into 10-bit code groups. It finds where the groups begin by searching for the K28.5 comma, in either running-disparity form. It keeps a sliding 10-bit window of the most recent bits and compares that window with both comma patterns on every accepted bit. A match anywhere in the stream, at any time, moves the word boundary so that the matched bits form the word that is emitted. That word carries a comma flag.

Bits count only while the upstream lock qualifier is high and the bit-valid strobe is asserted. When lock drops, the block clears the window, the bit counter and the fill count, and it stops producing words. After lock returns, the first word is built from the next ten accepted bits. A comma can only be recognised once ten real bits have entered the window since lock. The block does no decoding and no disparity checking.

Top module: `commaAligner`

## Requirements
- R1: While reset is asserted (rstN low), and on the first cycle after it, wordValid and commaFlag are 0 and wordOut is 0.
- R2: With lock held and no comma in the stream, one word is emitted for every ten accepted bits. The first bit accepted after lock lands in wordOut[9] and the tenth lands in wordOut[0].
- R3: The positive-disparity comma 0011111010 (first bit received on the left) is recognised when it fills the window. The window is then emitted as a word with commaFlag high.
- R4: The negative-disparity comma 1100000101 (first bit received on the left) is recognised and emitted in the same way as R3.
- R5: A comma whose last bit falls at any offset from the current boundary ends the current word early. The partial word is dropped, and the next word starts with the following accepted bit.
- R6: A comma that falls exactly on the current boundary leaves the alignment unchanged and no word is lost.
- R7: A cycle with bitValid low shifts nothing, counts nothing and emits no word.
- R8: While lockValid is low, wordValid stays low and the alignment state is cleared. After lock returns, words are counted from the first bit accepted after it.
- R9: commaFlag is high only in a cycle in which wordValid is high.
- R10: No comma is recognised until ten bits have been accepted since lock was regained. Bits held in the window from before lock do not count.
- R11: wordValid, wordOut and commaFlag are registered. They change in the clock cycle after the edge that accepted the final bit of the word, and wordOut holds its value between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Recovered serial data bit |
| bitValid | input | 1 | bitIn carries a new bit this cycle |
| lockValid | input | 1 | Upstream bit synchronisation is held |
| wordOut | output | 10 | Aligned code group, first received bit in bit 9 |
| wordValid | output | 1 | One-cycle strobe marking a new wordOut |
| commaFlag | output | 1 | The strobed word is a K28.5 comma |

## Verification
A pseudo-random stream with lock held checks the steady ten-bit cadence and the bit ordering. Commas of both polarities are then placed at every offset from the current boundary. This separates early realignment from realignment at the boundary, where the word must be kept, and shows that each polarity is recognised on its own. Gaps in bitValid and drops of lockValid show whether idle cycles are skipped rather than counted. A pattern of eight bits that would match a comma against a stale, zero-filled window shows whether the block waits for ten real bits after lock before it looks for a comma.

// File: rtl/commaAlignPkg.sv
package commaAlignPkg;
  localparam int WordW = 10;
  localparam int CntW = $clog2(WordW);
  localparam logic [CntW-1:0] LastPos = CntW'(WordW - 1);
  localparam logic [WordW-1:0] CommaPos = 10'b0011111010;
  localparam logic [WordW-1:0] CommaNeg = ~CommaPos;

  typedef struct packed {
    logic clearAll;
    logic shiftEn;
    logic emit;
    logic markComma;
  } alignCtrl_t;
endpackage

// File: rtl/alignDatapath.sv
module alignDatapath
  import commaAlignPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  alignCtrl_t       ctrl,
  output logic             commaHit,
  output logic [WordW-1:0] wordOut,
  output logic             wordValid,
  output logic             commaFlag
);
  logic [WordW-1:0] window;
  logic [WordW-1:0] nextWin;

  assign nextWin  = {window[WordW-2:0], bitIn};
  assign commaHit = (nextWin == CommaPos) || (nextWin == CommaNeg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      window    <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      commaFlag <= 1'b0;
    end else begin
      wordValid <= ctrl.emit;
      commaFlag <= ctrl.markComma;
      if (ctrl.clearAll) begin
        window <= '0;
      end else if (ctrl.shiftEn) begin
        window <= nextWin;
      end
      if (ctrl.emit) begin
        wordOut <= nextWin;
      end
    end
  end
endmodule

// File: rtl/alignControl.sv
module alignControl
  import commaAlignPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       lockValid,
  input  logic       commaHit,
  output alignCtrl_t ctrl
);
  logic [CntW-1:0] bitPos;
  logic [CntW-1:0] fillCnt;
  logic            windowFull;
  logic            shiftEn;
  logic            hitValid;
  logic            boundary;

  assign shiftEn    = bitValid && lockValid;
  assign windowFull = (fillCnt == LastPos);
  assign hitValid   = shiftEn && commaHit && windowFull;
  assign boundary   = shiftEn && (bitPos == LastPos);

  always_comb begin
    ctrl.clearAll  = !lockValid;
    ctrl.shiftEn   = shiftEn;
    ctrl.emit      = hitValid || boundary;
    ctrl.markComma = hitValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !lockValid) begin
      bitPos  <= '0;
      fillCnt <= '0;
    end else if (shiftEn) begin
      bitPos <= (hitValid || boundary) ? '0 : bitPos + 1'b1;
      if (!windowFull) begin
        fillCnt <= fillCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/commaAligner.sv
module commaAligner
  import commaAlignPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic             bitValid,
  input  logic             lockValid,
  output logic [WordW-1:0] wordOut,
  output logic             wordValid,
  output logic             commaFlag
);
  alignCtrl_t ctrl;
  logic       commaHit;

  alignControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitValid  (bitValid),
    .lockValid (lockValid),
    .commaHit  (commaHit),
    .ctrl      (ctrl)
  );

  alignDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .ctrl      (ctrl),
    .commaHit  (commaHit),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .commaFlag (commaFlag)
  );
endmodule

// File: rtl/commaAlignerChecker.sv
module commaAlignerChecker
  import commaAlignPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             bitValid,
  input logic             lockValid,
  input logic [WordW-1:0] wordOut,
  input logic             wordValid,
  input logic             commaFlag
);
  a_r9_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |-> wordValid);

  a_r3_r4_flag_is_comma: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |-> (wordOut == CommaPos || wordOut == CommaNeg));

  a_r8_quiet_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !lockValid |=> !wordValid);

  a_r7_strobe_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(bitValid && lockValid));

  a_r11_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));
endmodule

bind commaAligner commaAlignerChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .lockValid (lockValid),
  .wordOut   (wordOut),
  .wordValid (wordValid),
  .commaFlag (commaFlag)
);

// File: tb/commaAligner_bench.sv
module commaAligner_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0;
  logic       bitValid = 1'b0;
  logic       lockValid = 1'b0;
  logic [9:0] wordOut;
  logic       wordValid;
  logic       commaFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [9:0] expWord = '0;
  logic       expValid = 1'b0;
  logic       expFlag = 1'b0;
  int         hist[$];
  int         sinceBound = 0;
  int         lfsr = 32'h1ace;
  string      tag = "R1";

  localparam logic [9:0] KPOS = 10'b0011111010;
  localparam logic [9:0] KNEG = 10'b1100000101;

  always #2 clk = ~clk;

  commaAligner u_commaAligner (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .lockValid(lockValid), .wordOut(wordOut), .wordValid(wordValid),
    .commaFlag(commaFlag)
  );

  task automatic compareNow();
    compared++;
    if (wordValid !== expValid) begin
      mismatched++;
      $display("FAIL %s/R11 wordValid act=%b exp=%b", tag, wordValid, expValid);
    end
    compared++;
    if (wordOut !== expWord) begin
      mismatched++;
      $display("FAIL %s/R2 wordOut act=%b exp=%b", tag, wordOut, expWord);
    end
    compared++;
    if (commaFlag !== expFlag) begin
      mismatched++;
      $display("FAIL %s/R9 commaFlag act=%b exp=%b", tag, commaFlag, expFlag);
    end
  endtask

  function automatic logic [9:0] histWord();
    logic [9:0] w = '0;
    foreach (hist[i]) w = {w[8:0], hist[i][0]};
    return w;
  endfunction

  task automatic step(input logic b, input logic v, input logic l, input logic r);
    logic isComma;
    @(negedge clk);
    compareNow();
    bitIn = b; bitValid = v; lockValid = l; rstN = r;
    if (!r) begin
      hist.delete(); sinceBound = 0;
      expValid = 0; expFlag = 0; expWord = '0;
    end else if (!l) begin
      hist.delete(); sinceBound = 0;
      expValid = 0; expFlag = 0;
    end else if (!v) begin
      expValid = 0; expFlag = 0;
    end else begin
      hist.push_back(int'(b));
      if (hist.size() > 10) void'(hist.pop_front());
      sinceBound++;
      isComma = (hist.size() == 10) &&
                (histWord() == KPOS || histWord() == KNEG);
      if (isComma || sinceBound == 10) begin
        expValid = 1; expFlag = isComma; expWord = histWord(); sinceBound = 0;
      end else begin
        expValid = 0; expFlag = 0;
      end
    end
  endtask

  task automatic sendBit(input logic b);
    step(b, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic randBits(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      sendBit(lfsr[0]);
    end
  endtask

  task automatic sendWord(input logic [9:0] w);
    for (int i = 9; i >= 0; i--) sendBit(w[i]);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung, act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    tag = "R2";
    sendWord(10'b1000000001);
    sendWord(10'b0110010110);
    randBits(60);
    tag = "R3";
    randBits(3); sendWord(KPOS); randBits(20);
    tag = "R4";
    randBits(7); sendWord(KNEG); randBits(20);
    tag = "R6";
    sendWord(KPOS); sendWord(10'b1010101010); sendWord(KNEG); sendWord(KPOS);
    randBits(10);
    tag = "R5";
    for (int off = 0; off < 10; off++) begin
      sendWord(KPOS); randBits(off + 10); sendWord((off % 2) ? KNEG : KPOS);
      randBits(10);
    end
    tag = "R7";
    for (int i = 0; i < 40; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      step(lfsr[0], lfsr[3] | lfsr[5], 1'b1, 1'b1);
    end
    sendWord(KNEG); randBits(10);
    tag = "R8";
    randBits(4);
    for (int i = 0; i < 6; i++) step(i[0], 1'b1, 1'b0, 1'b1);
    sendWord(10'b1111100000); randBits(25);
    tag = "R10";
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, 1'b1);
    sendBit(1); sendBit(1); sendBit(1); sendBit(1);
    sendBit(1); sendBit(0); sendBit(1); sendBit(0);
    randBits(12);
    sendWord(KPOS); randBits(10);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule